// File: doc/BRIEF.md
# Dynamic Priority Task Selector

The block picks which of `N_CTX` hardware task contexts should run next. Every context has two inputs: an event-pending line and a scheduler-enable line. A context is a candidate only while both are high. Context 0 is pinned to priority 0, which is the most urgent level. Every other context holds a priority register that software can program with a value from 1 to `N_CTX-1`.

In each cycle the block turns the stored priorities into one ready line per priority level. A level's line is high when at least one candidate context is programmed to that level. Context 0's candidacy drives level 0 directly. A fixed-order encoder then takes the lowest-numbered ready level. A second encoder of the same kind takes the lowest-indexed candidate inside that level. The result is registered as a context ID, the winning level and a valid flag.

A single write port updates the priorities. A write is accepted only when it comes from context 0 and names a legal context and a legal priority. An accepted write first steers the selection registered on the following clock edge.

Top module: `dyn_prio_selector`

## Requirements
- R1: While `rst_n` is low, and after its release until the first candidate appears, `sel_valid` is 0 and `sel_task` and `sel_level` are 0. Reset loads context i (i ≥ 1) with priority i.
- R2: Whenever context 0 has both `evt_pend[0]` and `sched_en[0]` high, the next registered selection is `sel_task`=0 and `sel_level`=0, whatever the other contexts hold.
- R3: A context whose `evt_pend` bit or `sched_en` bit is low is never selected.
- R4: Among the candidates, the context with the numerically smallest stored priority is selected, and `sel_level` reports that priority.
- R5: When several candidates share the smallest stored priority, the one with the lowest index is selected.
- R6: When no context is a candidate, `sel_valid` becomes 0 on the next edge, and `sel_task` and `sel_level` keep their previous values.
- R7: A write with `wr_en`=1, `wr_src`=0, `wr_ctx` in 1..N_CTX-1 and `wr_prio` in 1..N_CTX-1 stores `wr_prio` for `wr_ctx` at the clock edge. The selection registered at that same edge still uses the old value. The selection registered at the next edge uses the new value.
- R8: A write with `wr_src` other than 0 leaves every stored priority unchanged.
- R9: A write of priority 0 (or of a value ≥ N_CTX), or a write that targets context 0, leaves every stored priority unchanged. Every stored priority of contexts 1..N_CTX-1 stays within 1..N_CTX-1.
- R10: Selection outputs are registered: they reflect the inputs and priorities present before the clock edge that loads them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pend | input | N_CTX | Event-pending line per context |
| sched_en | input | N_CTX | Scheduler enable per context |
| wr_en | input | 1 | Priority write strobe |
| wr_src | input | IW | ID of the context issuing the write |
| wr_ctx | input | IW | Context whose priority is written |
| wr_prio | input | IW | New priority value |
| sel_valid | output | 1 | A context was selected in this cycle |
| sel_task | output | IW | Selected context ID |
| sel_level | output | IW | Priority level of the selected context |

## Verification
The checker assumes that all inputs carry known values at each rising edge outside reset. It also assumes that `N_CTX` fits the ID width, so every context index can be written on `wr_ctx`. The stimulus drives every input after the falling edge, from a fixed seed. It draws write fields across the whole ID range, so foreign sources, priority 0 and writes aimed at context 0 all occur. It biases the write source toward context 0 so that accepted writes keep reshuffling the levels. Ties arise because accepted writes often place several contexts on one level, and directed steps force the tie, idle and context-0 cases in addition.

// File: rtl/dps_pkg.sv
package dps_pkg;

  // Legality of a priority write: source must be context 0, the target
  // must be a programmable context and the value a non-zero level.
  function automatic bit dps_write_legal(input int src, input int ctx,
                                         input int prio, input int n);
    return (src == 0) && (ctx >= 1) && (ctx < n) && (prio >= 1) && (prio < n);
  endfunction

  // Number of bits needed for an ID among n entries (at least 1).
  function automatic int dps_id_bits(input int n);
    int b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction

endpackage

// File: rtl/dps_first_enc.sv
// Fixed-order encoder: reports the lowest-numbered asserted request.
module dps_first_enc #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dps_prio_regs.sv
// Priority storage: context 0 reads as level 0, the others are programmable.
module dps_prio_regs
  import dps_pkg::*;
#(
  parameter int N_CTX = 8,
  parameter int IW    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_src,
  input  logic [IW-1:0]             wr_ctx,
  input  logic [IW-1:0]             wr_prio,
  output logic                      wr_accept,
  output logic [N_CTX-1:0][IW-1:0]  prio_q
);
  assign wr_accept = wr_en &&
    dps_write_legal(int'(wr_src), int'(wr_ctx), int'(wr_prio), N_CTX);

  assign prio_q[0] = '0;

  for (genvar g = 1; g < N_CTX; g++) begin : g_slot
    logic [IW-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= IW'(g);
      end else if (wr_accept && (wr_ctx == IW'(g))) begin
        slot_q <= wr_prio;
      end
    end
    assign prio_q[g] = slot_q;
  end
endmodule

// File: rtl/dps_level_map.sv
// Builds one ready line per priority level plus the member mask of each level.
module dps_level_map #(
  parameter int N_CTX = 8,
  parameter int IW    = 3
) (
  input  logic [N_CTX-1:0]           active,
  input  logic [N_CTX-1:0][IW-1:0]   prio_q,
  output logic [N_CTX-1:0][N_CTX-1:0] lvl_mask,
  output logic [N_CTX-1:0]           lvl_ready
);
  // Level 0 belongs to context 0 alone.
  assign lvl_mask[0]  = {{(N_CTX-1){1'b0}}, active[0]};
  assign lvl_ready[0] = active[0];

  for (genvar k = 1; k < N_CTX; k++) begin : g_level
    assign lvl_mask[k][0] = 1'b0;
    for (genvar c = 1; c < N_CTX; c++) begin : g_member
      assign lvl_mask[k][c] = active[c] && (prio_q[c] == IW'(k));
    end
    assign lvl_ready[k] = |lvl_mask[k];
  end
endmodule

// File: rtl/dyn_prio_selector.sv
module dyn_prio_selector
  import dps_pkg::*;
#(
  parameter int N_CTX = 8,
  parameter int IW    = dps_id_bits(N_CTX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CTX-1:0] evt_pend,
  input  logic [N_CTX-1:0] sched_en,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_src,
  input  logic [IW-1:0]    wr_ctx,
  input  logic [IW-1:0]    wr_prio,
  output logic             sel_valid,
  output logic [IW-1:0]    sel_task,
  output logic [IW-1:0]    sel_level
);
  // Named internal events for the checker.
  logic [N_CTX-1:0]            active;
  logic                        wr_accept;
  logic [N_CTX-1:0][IW-1:0]    prio_q;
  logic [N_CTX-1:0][N_CTX-1:0] lvl_mask;
  logic [N_CTX-1:0]            lvl_ready;
  logic                        lvl_any;
  logic [IW-1:0]               win_level;
  logic                        ctx_any;
  logic [IW-1:0]               win_ctx;
  logic [N_CTX-1:0]            win_members;

  assign active = evt_pend & sched_en;

  dps_prio_regs #(.N_CTX(N_CTX), .IW(IW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_src    (wr_src),
    .wr_ctx    (wr_ctx),
    .wr_prio   (wr_prio),
    .wr_accept (wr_accept),
    .prio_q    (prio_q)
  );

  dps_level_map #(.N_CTX(N_CTX), .IW(IW)) u_map (
    .active    (active),
    .prio_q    (prio_q),
    .lvl_mask  (lvl_mask),
    .lvl_ready (lvl_ready)
  );

  // Static-order encoder over levels: lowest level wins.
  dps_first_enc #(.W(N_CTX), .IW(IW)) u_level_enc (
    .req (lvl_ready),
    .any (lvl_any),
    .idx (win_level)
  );

  assign win_members = lvl_mask[win_level];

  // Same encoder inside the winning level: lowest index breaks ties.
  dps_first_enc #(.W(N_CTX), .IW(IW)) u_ctx_enc (
    .req (win_members),
    .any (ctx_any),
    .idx (win_ctx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_task  <= '0;
      sel_level <= '0;
    end else if (lvl_any && ctx_any) begin
      sel_valid <= 1'b1;
      sel_task  <= win_ctx;
      sel_level <= win_level;
    end else begin
      sel_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dps_sel_checker.sv
module dps_sel_checker #(
  parameter int N_CTX = 8,
  parameter int IW    = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_CTX-1:0]         active,
  input logic                     wr_en,
  input logic [IW-1:0]            wr_src,
  input logic [N_CTX-1:0][IW-1:0] prio_q,
  input logic                     sel_valid,
  input logic [IW-1:0]            sel_task,
  input logic [IW-1:0]            sel_level
);
  logic [N_CTX-1:0] act_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_d <= '0;
    else        act_d <= active;
  end

  p_ctx0_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active[0] |=> (sel_valid && sel_task == '0 && sel_level == '0));

  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|active) |=> (!sel_valid && $stable(sel_task) && $stable(sel_level)));

  p_busy_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|active) |=> sel_valid);

  p_pick_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> act_d[sel_task]);

  p_foreign_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_src != '0) |=> $stable(prio_q));

  // R9: stored levels stay legal
  always_ff @(posedge clk) begin
    if (rst_n) begin
      p_ctx0_level_r9: assert (prio_q[0] == '0);
      for (int c = 1; c < N_CTX; c++) begin
        p_prio_legal_r9: assert (prio_q[c] != '0 && int'(prio_q[c]) < N_CTX);
      end
    end
  end
endmodule

bind dyn_prio_selector dps_sel_checker #(.N_CTX(N_CTX), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .active    (active),
  .wr_en     (wr_en),
  .wr_src    (wr_src),
  .prio_q    (prio_q),
  .sel_valid (sel_valid),
  .sel_task  (sel_task),
  .sel_level (sel_level)
);

// File: tb/dyn_prio_selector_tb.sv
module dyn_prio_selector_tb;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_pend = '0;
  logic [N-1:0]  sched_en = '0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_src = '0, wr_ctx = '0, wr_prio = '0;
  logic          sel_valid;
  logic [IW-1:0] sel_task, sel_level;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int mprio [N];
  bit exp_v;
  int exp_t, exp_l;

  always #10 clk = ~clk;

  dyn_prio_selector #(.N_CTX(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_pend(evt_pend), .sched_en(sched_en),
    .wr_en(wr_en), .wr_src(wr_src), .wr_ctx(wr_ctx), .wr_prio(wr_prio),
    .sel_valid(sel_valid), .sel_task(sel_task), .sel_level(sel_level)
  );

  // Expected pick: scan contexts, keep strictly smaller level (index order breaks ties).
  function automatic void model_pick(input logic [N-1:0] ev, input logic [N-1:0] en,
                                     output bit v, output int t, output int l,
                                     output bit tie);
    v = 0; t = 0; l = N; tie = 0;
    for (int c = 0; c < N; c++) begin
      if (ev[c] && en[c]) begin
        if (!v || mprio[c] < l) begin
          v = 1; t = c; l = mprio[c]; tie = 0;
        end else if (mprio[c] == l) begin
          tie = 1;
        end
      end
    end
  endfunction

  function automatic bit model_legal(input int s, input int c, input int p);
    return s == 0 && c != 0 && c < N && p != 0 && p < N;
  endfunction

  task automatic check(input string req, input bit v, input int t, input int l);
    checks++;
    if (sel_valid !== v || (v && (int'(sel_task) != t || int'(sel_level) != l))
        || (!v && (int'(sel_task) != t || int'(sel_level) != l))) begin
      errors++;
      $display("FAIL %s: got valid=%0d task=%0d level=%0d, expected valid=%0d task=%0d level=%0d",
               req, sel_valid, sel_task, sel_level, v, t, l);
    end
  endtask

  // One cycle: drive at falling edge, register at rising edge, compare at next falling edge.
  task automatic step(input logic [N-1:0] ev, input logic [N-1:0] en, input bit we,
                      input int s, input int c, input int p, input string req);
    bit v, tie;
    int t, l;
    evt_pend = ev; sched_en = en; wr_en = we;
    wr_src = IW'(s); wr_ctx = IW'(c); wr_prio = IW'(p);
    model_pick(ev, en, v, t, l, tie);
    if (v) begin exp_v = 1; exp_t = t; exp_l = l; end
    else exp_v = 0;
    @(posedge clk);
    if (we && model_legal(s, c, p)) mprio[c] = p;
    @(negedge clk);
    check(req, exp_v, exp_t, exp_l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < N; c++) mprio[c] = c;
    exp_v = 0; exp_t = 0; exp_l = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 0, 0, 0);

    // R1/R4: reset priorities equal index
    step(8'b0010_1000, 8'hFF, 0, 0, 0, 0, "R1 R4 reset levels");
    // R2: context 0 beats everyone
    step(8'b1111_1111, 8'hFF, 0, 0, 0, 0, "R2 ctx0 top");
    // R3 + R6: events without enables, hold previous
    step(8'b1111_1110, 8'h01, 0, 0, 0, 0, "R3 R6 no enable");
    step(8'b0000_0001, 8'hFE, 0, 0, 0, 0, "R3 R6 ctx0 disabled");
    // R8: foreign write ignored
    step(8'b0000_0000, 8'h00, 1, 2, 5, 1, "R8 foreign write");
    step(8'b0010_1000, 8'hFF, 0, 0, 0, 0, "R8 unchanged");
    // R9: priority 0 and context 0 targets ignored
    step(8'b0000_0000, 8'h00, 1, 0, 5, 0, "R9 zero level");
    step(8'b0000_0000, 8'h00, 1, 0, 0, 7, "R9 ctx0 target");
    step(8'b0010_1001, 8'hFE, 0, 0, 0, 0, "R9 unchanged");
    // R7: accepted write, old value on same edge, new one next edge
    step(8'b0010_1000, 8'hFF, 1, 0, 5, 1, "R7 same edge old");
    step(8'b0010_1000, 8'hFF, 0, 0, 0, 0, "R7 next edge new");
    // R5: ties resolved by lower index
    step(8'b0000_0000, 8'h00, 1, 0, 6, 1, "R5 setup");
    step(8'b0110_0000, 8'hFF, 0, 0, 0, 0, "R5 tie lower index");
    step(8'b0100_0000, 8'hFF, 0, 0, 0, 0, "R5 single member");
    step(8'b0000_0000, 8'hFF, 0, 0, 0, 0, "R6 idle hold");

    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] ev, en;
      bit we, v, tie;
      int s, c, p, t, l;
      string req;
      ev = N'($urandom);
      en = N'($urandom) | N'($urandom);
      if (($urandom % 4) == 0) ev[0] = 1'b0;
      if (($urandom % 3) != 0) ev = ev & N'($urandom);
      we = ($urandom % 3) == 0;
      s = (($urandom % 2) == 0) ? 0 : int'($urandom % N);
      c = int'($urandom % N);
      p = int'($urandom % N);
      model_pick(ev, en, v, t, l, tie);
      if (!v) req = "R6 random idle";
      else if (t == 0) req = "R2 random";
      else if (tie) req = "R5 random tie";
      else req = "R4 R10 random";
      step(ev, en, we, s, c, p, req);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule